// File: doc/BRIEF.md
# General-Purpose Power Event Status Collector

This block gathers a vector of general-purpose power-management event lines and turns each one into a latched, software-visible status bit. The lower part of the vector belongs to the working power domain. The upper part belongs to the standby domain. Each input is first brought into the clock domain through a synchroniser. An event is then taken on the rising edge of that synchronised input. Whether the event counts depends on three things: its enable bit, which domain the bit belongs to, and the current power state (Working, Sleep or Standby).

A counted event always latches its status bit. While any enabled status bit is set, the block holds a level-sensitive system control interrupt (SCI). Events counted in Sleep, and standby-domain events counted in Standby, also set a wake flag and emit a one-cycle wake request to the state sequencer. Working-domain events are discarded in Standby.

Software reaches the block through a plain single-cycle register port. A write is taken on the clock edge where `reg_we` is high. Read data follows `reg_addr` combinationally. The port is not a stream, so it has no valid/ready handshake and no back-pressure.

Top module: `gpe_event_status`

## Requirements
- R1: After reset, the enable register, the status register and the wake flag are all zero, and `sci` and `wake_req` are low.
- R2: Register addresses are: 0 = enable (read/write, one bit per event), 1 = status, 2 = wake word (the flag sits in bit 15, and every other bit reads 0), 3 = reads 0. `reg_rdata` reflects `reg_addr` in the same cycle.
- R3: An event whose enable bit is 0 sets no status bit, raises no SCI and sets no wake flag.
- R4: With `pwr_state` = 0 (Working; code 3 behaves the same), an enabled event sets its status bit and raises `sci`. It leaves the wake flag clear and `wake_req` low.
- R5: With `pwr_state` = 1 (Sleep), an enabled event on any bit sets its status bit, raises `sci`, sets the wake flag and pulses `wake_req` for exactly one cycle.
- R6: With `pwr_state` = 2 (Standby), an enabled event on bits 24 to 31 sets its status bit, sets the wake flag and pulses `wake_req`.
- R7: With `pwr_state` = 2 (Standby), events on bits 0 to 23 have no effect on status, wake flag, `sci` or `wake_req`.
- R8: Status bits and the wake flag are write-one-to-clear. Writing 1 clears the bit. Writing 0 leaves it unchanged.
- R9: If a status bit is being set and cleared on the same edge, the bit ends up set.
- R10: `sci` is high exactly while some status bit and its enable bit are both 1. Clearing the enable drops `sci` while the status bit stays readable.
- R11: Only a 0-to-1 transition counts. A line held high sets its bit once, and after a clear the bit stays clear while the line remains high.
- R12: A rise on an event input becomes visible in status, `sci` and `wake_req` after the third rising clock edge (two synchroniser stages, then the status register).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_in | input | 32 | Raw event lines; bits 0-23 working domain, 24-31 standby domain |
| pwr_state | input | 2 | Current power state: 0 Working, 1 Sleep, 2 Standby, 3 treated as Working |
| reg_we | input | 1 | Register write strobe, taken on the clock edge |
| reg_addr | input | 2 | Register address for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| sci | output | 1 | Level-sensitive system control interrupt |
| wake_req | output | 1 | One-cycle wake request to the state sequencer |

## Verification
The properties assume that `pwr_state` is stable on the edge where a qualified event lands. They also assume that reset starts every register from zero, so that each newly set status bit can be traced to an enable bit of the previous cycle. The stimulus changes every input only on the falling clock edge. It moves `pwr_state` only while the event lines are quiet, and it keeps each event pulse longer than the synchroniser depth. The set-versus-clear collision is the only case where a register write is placed on the exact edge where a status bit lands.

// File: rtl/gpe_pkg.sv
package gpe_pkg;
  typedef enum logic [1:0] {
    PS_WORK  = 2'd0,
    PS_SLEEP = 2'd1,
    PS_STBY  = 2'd2,
    PS_RSVD  = 2'd3
  } pstate_e;

  typedef enum logic [1:0] {
    RA_ENABLE = 2'd0,
    RA_STATUS = 2'd1,
    RA_WAKE   = 2'd2,
    RA_NONE   = 2'd3
  } raddr_e;

  localparam int unsigned WAKE_BIT = 15;
endpackage

// File: rtl/gpe_edge_sync.sv
module gpe_edge_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  output logic [W-1:0] rise
);
  logic [W-1:0] chain [STAGES];
  logic [W-1:0] last_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain[g] <= '0;
      end else begin
        if (g == 0) chain[g] <= raw;
        else        chain[g] <= chain[(g == 0) ? 0 : g-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= '0;
    else        last_q <= chain[STAGES-1];
  end

  assign rise = chain[STAGES-1] & ~last_q;
endmodule

// File: rtl/gpe_qualify.sv
module gpe_qualify
  import gpe_pkg::*;
#(
  parameter int unsigned W       = 32,
  parameter int unsigned STBY_LO = 24
) (
  input  logic [W-1:0] rise,
  input  logic [W-1:0] en,
  input  logic [1:0]   state,
  output logic [W-1:0] set_vec,
  output logic         wake_hit
);
  pstate_e      st;
  logic [W-1:0] allowed;

  assign st = pstate_e'(state);

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i >= STBY_LO) begin : g_stby_dom
      assign allowed[i] = 1'b1;
    end else begin : g_work_dom
      assign allowed[i] = (st != PS_STBY);
    end
  end

  assign set_vec  = rise & en & allowed;
  assign wake_hit = (|set_vec) && ((st == PS_SLEEP) || (st == PS_STBY));
endmodule

// File: rtl/gpe_regs.sv
module gpe_regs
  import gpe_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] set_vec,
  input  logic         wake_hit,
  output logic [W-1:0] en_q,
  output logic [W-1:0] sts_q,
  output logic         wak_q,
  output logic         wake_req,
  output logic [W-1:0] rdata
);
  raddr_e       ra;
  logic [W-1:0] sts_clr;
  logic         wak_clr;
  logic [W-1:0] wake_word;

  assign ra      = raddr_e'(addr);
  assign sts_clr = (we && ra == RA_STATUS) ? wdata : '0;
  assign wak_clr = we && (ra == RA_WAKE) && wdata[WAKE_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= '0;
      sts_q    <= '0;
      wak_q    <= 1'b0;
      wake_req <= 1'b0;
    end else begin
      if (we && ra == RA_ENABLE) en_q <= wdata;
      sts_q    <= (sts_q & ~sts_clr) | set_vec;
      wak_q    <= (wak_q & ~wak_clr) | wake_hit;
      wake_req <= wake_hit;
    end
  end

  always_comb begin
    wake_word           = '0;
    wake_word[WAKE_BIT] = wak_q;
    case (ra)
      RA_ENABLE: rdata = en_q;
      RA_STATUS: rdata = sts_q;
      RA_WAKE:   rdata = wake_word;
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpe_event_status.sv
module gpe_event_status #(
  parameter int unsigned NUM_EVT     = 32,
  parameter int unsigned STBY_LO     = 24,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_in,
  input  logic [1:0]         pwr_state,
  input  logic               reg_we,
  input  logic [1:0]         reg_addr,
  input  logic [NUM_EVT-1:0] reg_wdata,
  output logic [NUM_EVT-1:0] reg_rdata,
  output logic               sci,
  output logic               wake_req
);
  logic [NUM_EVT-1:0] rise;
  logic [NUM_EVT-1:0] set_vec;
  logic [NUM_EVT-1:0] en_q;
  logic [NUM_EVT-1:0] sts_q;
  logic               wak_q;
  logic               wake_hit;

  gpe_edge_sync #(.W(NUM_EVT), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .raw(evt_in), .rise(rise)
  );

  gpe_qualify #(.W(NUM_EVT), .STBY_LO(STBY_LO)) qual_i (
    .rise(rise), .en(en_q), .state(pwr_state),
    .set_vec(set_vec), .wake_hit(wake_hit)
  );

  gpe_regs #(.W(NUM_EVT)) regs_i (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .set_vec(set_vec), .wake_hit(wake_hit),
    .en_q(en_q), .sts_q(sts_q), .wak_q(wak_q),
    .wake_req(wake_req), .rdata(reg_rdata)
  );

  assign sci = |(sts_q & en_q);
endmodule

// File: rtl/gpe_event_status_chk.sv
module gpe_event_status_chk
  import gpe_pkg::*;
#(
  parameter int unsigned NUM_EVT = 32,
  parameter int unsigned STBY_LO = 24
) (
  input logic               clk,
  input logic               rst_n,
  input logic [1:0]         pwr_state,
  input logic               reg_we,
  input logic [1:0]         reg_addr,
  input logic [NUM_EVT-1:0] reg_wdata,
  input logic               sci,
  input logic               wake_req,
  input logic [NUM_EVT-1:0] en_q,
  input logic [NUM_EVT-1:0] sts_q,
  input logic               wak_q,
  input logic [NUM_EVT-1:0] set_vec
);
  AST_SET_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    ((sts_q & ~$past(sts_q) & ~$past(en_q)) == '0)); // R3

  AST_STBY_WORK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == PS_STBY) |=>
      ((sts_q[STBY_LO-1:0] & ~$past(sts_q[STBY_LO-1:0])) == '0)); // R7

  AST_WORK_NO_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == PS_WORK) |=> !$rose(wak_q)); // R4

  AST_WAKE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> wak_q); // R5

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == RA_STATUS && set_vec == '0) |=>
      ((sts_q & $past(reg_wdata)) == '0)); // R8

  AST_SCI_HAS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    sci |-> (sts_q != '0)); // R10
endmodule

bind gpe_event_status gpe_event_status_chk #(.NUM_EVT(NUM_EVT), .STBY_LO(STBY_LO)) chk_i (
  .clk(clk), .rst_n(rst_n), .pwr_state(pwr_state), .reg_we(reg_we),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .sci(sci), .wake_req(wake_req),
  .en_q(en_q), .sts_q(sts_q), .wak_q(wak_q), .set_vec(set_vec)
);

// File: tb/gpe_event_status_tb_top.sv
module gpe_event_status_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] evt_in = '0;
  logic [1:0]  pwr_state = 2'd0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        sci;
  logic        wake_req;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  localparam logic [31:0] WAKE_MASK = 32'h0000_8000;

  always #4 clk = ~clk;

  gpe_event_status dut_i (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .pwr_state(pwr_state),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .sci(sci), .wake_req(wake_req)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic pulse(int b);
    @(negedge clk);
    evt_in[b] = 1'b1;
    tick(4);
    evt_in[b] = 1'b0;
    tick(3);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(2'd0, d); check("R1 enable", d, 32'h0);
    rd(2'd1, d); check("R1 status", d, 32'h0);
    rd(2'd2, d); check("R1 wake", d, 32'h0);
    check("R1 sci", {31'h0, sci}, 32'h0);
    check("R1 wake_req", {31'h0, wake_req}, 32'h0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(2'd0, 32'hA5C3_0F18);
    rd(2'd0, d); check("R2 enable readback", d, 32'hA5C3_0F18);
    wr(2'd2, 32'hFFFF_7FFF);
    rd(2'd2, d); check("R2 wake word", d, 32'h0);
    rd(2'd3, d); check("R2 unused addr", d, 32'h0);
    wr(2'd0, 32'hFFFF_FFFF);
  endtask

  task automatic t_working();
    logic [31:0] d;
    pwr_state = 2'd0;
    pulse(5);
    rd(2'd1, d); check("R4 status", d, 32'h20);
    check("R4 sci", {31'h0, sci}, 32'h1);
    rd(2'd2, d); check("R4 no wake", d, 32'h0);
    wr(2'd1, 32'h20);
    rd(2'd1, d); check("R4 cleared", d, 32'h0);
  endtask

  task automatic t_disabled();
    logic [31:0] d;
    wr(2'd0, ~32'h80);
    pulse(7);
    rd(2'd1, d); check("R3 status", d, 32'h0);
    check("R3 sci", {31'h0, sci}, 32'h0);
    wr(2'd0, 32'hFFFF_FFFF);
  endtask

  task automatic t_latency();
    logic [31:0] d;
    @(negedge clk);
    evt_in[2] = 1'b1;
    tick(2);
    rd(2'd1, d); check("R12 not yet", d, 32'h0);
    tick(1);
    rd(2'd1, d); check("R12 third edge", d, 32'h4);
    evt_in[2] = 1'b0;
    wr(2'd1, 32'h4);
  endtask

  task automatic t_sleep();
    logic [31:0] d;
    pwr_state = 2'd1;
    @(negedge clk);
    evt_in[9] = 1'b1;
    tick(2);
    check("R5 wake_req early", {31'h0, wake_req}, 32'h0);
    tick(1);
    check("R5 wake_req", {31'h0, wake_req}, 32'h1);
    rd(2'd1, d); check("R5 status", d, 32'h200);
    rd(2'd2, d); check("R5 wake flag", d, WAKE_MASK);
    check("R5 sci", {31'h0, sci}, 32'h1);
    tick(1);
    check("R5 pulse one cycle", {31'h0, wake_req}, 32'h0);
    evt_in[9] = 1'b0;
    wr(2'd1, 32'h200);
    wr(2'd2, WAKE_MASK);
  endtask

  task automatic t_standby();
    logic [31:0] d;
    pwr_state = 2'd2;
    @(negedge clk);
    evt_in[3] = 1'b1;
    tick(3);
    check("R7 no wake_req", {31'h0, wake_req}, 32'h0);
    evt_in[3] = 1'b0;
    tick(3);
    rd(2'd1, d); check("R7 status", d, 32'h0);
    rd(2'd2, d); check("R7 wake", d, 32'h0);
    check("R7 sci", {31'h0, sci}, 32'h0);
    @(negedge clk);
    evt_in[28] = 1'b1;
    tick(3);
    check("R6 wake_req", {31'h0, wake_req}, 32'h1);
    rd(2'd1, d); check("R6 status", d, 32'h1000_0000);
    rd(2'd2, d); check("R6 wake flag", d, WAKE_MASK);
    evt_in[28] = 1'b0;
    tick(2);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    pwr_state = 2'd0;
    wr(2'd1, 32'h0);
    rd(2'd1, d); check("R8 zero write keeps", d, 32'h1000_0000);
    wr(2'd2, 32'h0);
    rd(2'd2, d); check("R8 wake zero keeps", d, WAKE_MASK);
    wr(2'd1, 32'h1000_0000);
    rd(2'd1, d); check("R8 status cleared", d, 32'h0);
    wr(2'd2, WAKE_MASK);
    rd(2'd2, d); check("R8 wake cleared", d, 32'h0);
  endtask

  task automatic t_set_wins();
    logic [31:0] d;
    pulse(1);
    @(negedge clk);
    evt_in[1] = 1'b1;
    tick(2);
    reg_we = 1'b1; reg_addr = 2'd1; reg_wdata = 32'h2;
    tick(1);
    reg_we = 1'b0; reg_wdata = '0;
    rd(2'd1, d); check("R9 set wins", d, 32'h2);
    evt_in[1] = 1'b0;
    tick(2);
  endtask

  task automatic t_sci_level();
    logic [31:0] d;
    check("R10 sci on", {31'h0, sci}, 32'h1);
    wr(2'd0, ~32'h2);
    check("R10 sci off", {31'h0, sci}, 32'h0);
    rd(2'd1, d); check("R10 status kept", d, 32'h2);
    wr(2'd0, 32'hFFFF_FFFF);
    check("R10 sci back", {31'h0, sci}, 32'h1);
    wr(2'd1, 32'h2);
    check("R10 sci after clear", {31'h0, sci}, 32'h0);
  endtask

  task automatic t_held();
    logic [31:0] d;
    @(negedge clk);
    evt_in[4] = 1'b1;
    tick(4);
    rd(2'd1, d); check("R11 set once", d, 32'h10);
    wr(2'd1, 32'h10);
    tick(5);
    rd(2'd1, d); check("R11 held stays clear", d, 32'h0);
    evt_in[4] = 1'b0;
    tick(2);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    t_reset();
    rst_n = 1'b1;
    tick(2);
    t_regs();
    t_working();
    t_disabled();
    t_latency();
    t_sleep();
    t_standby();
    t_w1c();
    t_set_wins();
    t_sci_level();
    t_held();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule